// File: doc/BRIEF.md
# GPIO Port with Edge-Selectable Interrupts

This block is an eight-bit general-purpose I/O port controlled through a small byte-wide register file. Each register bit maps to one port bit. Software picks, bit by bit, whether the pin drives (direction), what it drives (output data), and whether a peripheral takes the pin over (function select). The block presents these as output-enable, output-value and select lines toward the pad ring. The pad ring and the peripherals are outside the block.

Every pin input passes through a two-flop synchronizer. The synchronized level can be read back, and it feeds a per-bit edge detector. A per-bit edge-select register picks rising or falling edges. A detected edge sets a sticky flag bit, and the port raises one interrupt request whenever an enabled flag is set. Two build options are available. One removes the interrupt logic altogether. The other bonds fewer pins than there are register bits, while still keeping all eight control bits in every register.

Top module: `gpio_edge_port`

## Requirements
- R1: During and after a synchronous reset, every register, `pin_out`, `pin_oe`, `pin_func`, `irq` and `reg_rdata` are 0.
- R2: Register offsets on `reg_addr` are: 0 input level, 1 output data, 2 direction (1 = drive), 3 interrupt flag, 4 edge select, 5 interrupt enable, 6 function select, 7 unused (reads 0). A write at offset 1, 2 or 6 shows on `pin_out`, `pin_oe` or `pin_func` one clock after the write edge.
- R3: `reg_rdata` is registered. The register addressed at a clock edge is presented after that edge, and it shows the value the register held before that edge.
- R4: Offset 0 returns the pin level after a two-flop synchronizer. A pin change made before edge k appears in a read issued at edge k+2, and unbonded bits read 0.
- R5: Edge select bit 0 means rising and 1 means falling. A qualifying pin transition made before edge k sets the flag bit at edge k+2. A transition of the opposite polarity does not set it.
- R6: Writing offset 3 loads the flag register (1 sets, 0 clears). When a hardware edge and a software write of 0 arrive in the same cycle, the edge wins and the bit ends up set.
- R7: `irq` is registered and equals the OR over all bits of (flag AND enable) as it stood in the previous cycle.
- R8: Writing the edge select register with the pins stable never sets a flag.
- R9: All eight bits of the output, direction and select registers can be written and read back, even when `PIN_CNT` is less than 8. The pin ports are only `PIN_CNT` wide.
- R10: With `HAS_IRQ` = 0, offsets 3 to 5 read 0, writes to them have no effect, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | PIN_CNT | Asynchronous pin levels |
| pin_out | output | PIN_CNT | Output data toward the pads |
| pin_oe | output | PIN_CNT | Per-pin output enable |
| pin_func | output | PIN_CNT | Per-pin peripheral select |
| irq | output | 1 | Port interrupt request |

## Verification
Each result has its own latency. Written control values reach the pin lines one edge after the write. Read data is ready one edge after the address. A pin change reaches the input read path two edges later, a flag one edge after that, and `irq` a further edge later. The bench drives inputs on the falling edge and runs a behavioural model that updates on the same rising edges, so each port is compared against its expected value half a period after every edge. The directed checks wait exactly those edge counts; for example, the collision test places a flag-clear write on the edge at which an edge detection lands.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_IN   = 3'd0,
    OFS_OUT  = 3'd1,
    OFS_DIR  = 3'd2,
    OFS_FLAG = 3'd3,
    OFS_EDGE = 3'd4,
    OFS_IEN  = 3'd5,
    OFS_FSEL = 3'd6,
    OFS_NONE = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  reg_ofs_e     wr_ofs,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] fsel_q
);
  localparam int NREG = 3;
  logic [NREG-1:0][W-1:0] bank_q;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam reg_ofs_e SLOT_OFS = (g == 0) ? OFS_OUT : (g == 1) ? OFS_DIR : OFS_FSEL;
    always_ff @(posedge clk) begin
      if (rst) bank_q[g] <= '0;
      else if (wr_en && wr_ofs == SLOT_OFS) bank_q[g] <= wdata;
    end
  end

  assign out_q  = bank_q[0];
  assign dir_q  = bank_q[1];
  assign fsel_q = bank_q[2];

  p_out_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ofs == OFS_OUT) |=> (out_q == $past(wdata)));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ofs == OFS_DIR) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  reg_ofs_e     wr_ofs,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] edge_q,
  output logic [W-1:0] ien_q,
  output logic         irq_o
);
  logic [W-1:0] hit;
  logic         wr_flag, wr_edge, wr_ien;

  assign wr_flag = wr_en && (wr_ofs == OFS_FLAG);
  assign wr_edge = wr_en && (wr_ofs == OFS_EDGE);
  assign wr_ien  = wr_en && (wr_ofs == OFS_IEN);
  assign hit     = (rise_i & ~edge_q) | (fall_i & edge_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_edge) edge_q <= wdata;
      if (wr_ien)  ien_q  <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flag_q[i] <= 1'b0;
      else if (hit[i])  flag_q[i] <= 1'b1;
      else if (wr_flag) flag_q[i] <= wdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flag_q & ien_q);
  end

  p_edge_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));
  p_flag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (hit == '0 && !wr_flag) |=> $stable(flag_q));
  p_edge_sel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_edge && hit == '0) |=> $stable(flag_q));
  p_irq_low_r7: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ien_q) == '0) |=> !irq_o);
  p_irq_high_r7: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ien_q) != '0) |=> irq_o);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PIN_CNT = 8,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] pin_oe,
  output logic [PIN_CNT-1:0] pin_func,
  output logic               irq
);
  reg_ofs_e          ofs;
  logic [PIN_CNT-1:0] lvl, rise, fall;
  logic [DATA_W-1:0]  lvl_ext, rise_ext, fall_ext;
  logic [DATA_W-1:0]  out_q, dir_q, fsel_q, flag_q, edge_q, ien_q;
  logic [DATA_W-1:0]  rd_mux;

  assign ofs = reg_ofs_e'(reg_addr);

  gpio_in_sync #(.W(PIN_CNT)) u_sync (
    .clk(clk), .rst(rst), .pad_i(pin_in),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign lvl_ext  = DATA_W'(lvl);
  assign rise_ext = DATA_W'(rise);
  assign fall_ext = DATA_W'(fall);

  gpio_ctrl_regs #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_ofs(ofs), .wdata(reg_wdata[DATA_W-1:0]),
    .out_q(out_q), .dir_q(dir_q), .fsel_q(fsel_q)
  );

  if (HAS_IRQ) begin : g_irq
    gpio_irq_unit #(.W(DATA_W)) u_irq (
      .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_ofs(ofs), .wdata(reg_wdata[DATA_W-1:0]),
      .rise_i(rise_ext), .fall_i(fall_ext),
      .flag_q(flag_q), .edge_q(edge_q), .ien_q(ien_q), .irq_o(irq)
    );
  end else begin : g_noirq
    assign flag_q = '0;
    assign edge_q = '0;
    assign ien_q  = '0;
    assign irq    = 1'b0;

    p_irq_absent_r10: assert property (@(posedge clk) disable iff (rst) !irq);
  end

  always_comb begin
    unique case (ofs)
      OFS_IN:   rd_mux = lvl_ext;
      OFS_OUT:  rd_mux = out_q;
      OFS_DIR:  rd_mux = dir_q;
      OFS_FLAG: rd_mux = flag_q;
      OFS_EDGE: rd_mux = edge_q;
      OFS_IEN:  rd_mux = ien_q;
      OFS_FSEL: rd_mux = fsel_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= 8'(rd_mux);
  end

  assign pin_out  = out_q[PIN_CNT-1:0];
  assign pin_oe   = dir_q[PIN_CNT-1:0];
  assign pin_func = fsel_q[PIN_CNT-1:0];

  p_unused_ofs_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'd7) |=> (reg_rdata == 8'h00));
  p_read_out_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'd1) |=> (reg_rdata == 8'($past(out_q))));
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pins = 8'h00;
  logic [7:0] rdata, p_out, p_oe, p_func;
  logic       irq;

  logic       l_wr = 1'b0;
  logic [2:0] l_addr = 3'd0;
  logic [7:0] l_wdata = 8'h00;
  logic [5:0] l_pins = 6'h00;
  logic [7:0] l_rdata;
  logic [5:0] l_out, l_oe, l_func;
  logic       l_irq;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pins), .pin_out(p_out), .pin_oe(p_oe),
    .pin_func(p_func), .irq(irq)
  );

  gpio_edge_port #(.PIN_CNT(6), .HAS_IRQ(1'b0)) u_gpio_edge_port_lite (
    .clk(clk), .rst(rst), .reg_wr(l_wr), .reg_addr(l_addr), .reg_wdata(l_wdata),
    .reg_rdata(l_rdata), .pin_in(l_pins), .pin_out(l_out), .pin_oe(l_oe),
    .pin_func(l_func), .irq(l_irq)
  );

  // behavioural reference for the full port
  logic [7:0] m_s1, m_s2, m_prev, m_out, m_dir, m_fsel, m_flag, m_edge, m_ien, m_rd;
  logic       m_irq;
  always @(posedge clk) begin
    logic [7:0] nf;
    logic [7:0] rd;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_out <= 0; m_dir <= 0; m_fsel <= 0;
      m_flag <= 0; m_edge <= 0; m_ien <= 0; m_rd <= 0; m_irq <= 0;
    end else begin
      case (addr)
        3'd0: rd = m_s2;   3'd1: rd = m_out;  3'd2: rd = m_dir;
        3'd3: rd = m_flag; 3'd4: rd = m_edge; 3'd5: rd = m_ien;
        3'd6: rd = m_fsel; default: rd = 8'h00;
      endcase
      nf = (wr && addr == 3'd3) ? wdata : m_flag;
      for (int i = 0; i < 8; i++) begin
        if (m_edge[i] ? (m_prev[i] && !m_s2[i]) : (!m_prev[i] && m_s2[i])) nf[i] = 1'b1;
      end
      m_rd <= rd;
      m_irq <= |(m_flag & m_ien);
      m_flag <= nf;
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      if (wr && addr == 3'd1) m_out  <= wdata;
      if (wr && addr == 3'd2) m_dir  <= wdata;
      if (wr && addr == 3'd6) m_fsel <= wdata;
      if (wr && addr == 3'd4) m_edge <= wdata;
      if (wr && addr == 3'd5) m_ien  <= wdata;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 pin_out", p_out, m_out);
      check("R2 pin_oe", p_oe, m_dir);
      check("R2 pin_func", p_func, m_fsel);
      check("R3 reg_rdata", rdata, m_rd);
      check("R7 irq", {7'd0, irq}, {7'd0, m_irq});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wr_main(input logic [2:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_main(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wr_lite(input logic [2:0] a, input logic [7:0] d);
    l_wr = 1'b1; l_addr = a; l_wdata = d;
    @(negedge clk);
    l_wr = 1'b0;
  endtask

  task automatic rd_lite(input logic [2:0] a, output logic [7:0] d);
    l_addr = a;
    @(negedge clk);
    d = l_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 pin_out", p_out, 8'h00);
    check("R1 pin_oe", p_oe, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst = 1'b0;
    for (int a = 0; a < 8; a++) begin
      rd_main(3'(a), v);
      check("R1 register after reset", v, 8'h00);
    end

    // R2: control registers drive the pin lines
    wr_main(3'd1, 8'hA5);
    check("R2 pin_out after write", p_out, 8'hA5);
    wr_main(3'd2, 8'h0F);
    check("R2 pin_oe after write", p_oe, 8'h0F);
    wr_main(3'd6, 8'h3C);
    check("R2 pin_func after write", p_func, 8'h3C);
    rd_main(3'd2, v); check("R2 read direction", v, 8'h0F);
    rd_main(3'd7, v); check("R2 unused offset", v, 8'h00);

    // R5: rising edge on bit 0 with edge select 0
    pins = 8'h01;
    repeat (4) @(negedge clk);
    rd_main(3'd3, v); check("R5 rising edge flag", v, 8'h01);
    wr_main(3'd3, 8'h00);
    wr_main(3'd4, 8'h02);
    pins = 8'h03;
    repeat (4) @(negedge clk);
    rd_main(3'd3, v); check("R5 rise ignored when falling selected", v, 8'h00);
    pins = 8'h01;
    repeat (4) @(negedge clk);
    rd_main(3'd3, v); check("R5 falling edge flag", v, 8'h02);

    // R8: edge select changes with stable pins
    wr_main(3'd4, 8'hFF);
    wr_main(3'd4, 8'h00);
    repeat (2) @(negedge clk);
    rd_main(3'd3, v); check("R8 edge select write sets nothing", v, 8'h02);

    // R6: software set/clear, then collision with a hardware edge
    wr_main(3'd3, 8'h80);
    rd_main(3'd3, v); check("R6 software flag write", v, 8'h80);
    pins = 8'h05;
    @(negedge clk);
    @(negedge clk);
    wr_main(3'd3, 8'h00);
    rd_main(3'd3, v); check("R6 edge beats clear", v, 8'h04);

    // R7: interrupt request
    wr_main(3'd5, 8'h04);
    @(negedge clk);
    check("R7 irq asserted", {7'd0, irq}, 8'h01);
    wr_main(3'd5, 8'h00);
    @(negedge clk);
    check("R7 irq released", {7'd0, irq}, 8'h00);

    // R4: synchronizer latency on the input read
    addr = 3'd0;
    @(negedge clk);
    pins = 8'h5A;
    @(negedge clk); check("R4 input not yet visible", rdata, 8'h05);
    @(negedge clk); check("R4 input still old", rdata, 8'h05);
    @(negedge clk); check("R4 input visible", rdata, 8'h5A);

    // R9 / R10 / R4 on the reduced, interrupt-free variant
    wr_lite(3'd1, 8'hFF);
    check("R9 narrow pin_out", {2'b00, l_out}, 8'h3F);
    rd_lite(3'd1, v); check("R9 all eight output bits kept", v, 8'hFF);
    wr_lite(3'd2, 8'hC3);
    rd_lite(3'd2, v); check("R9 all eight direction bits kept", v, 8'hC3);
    wr_lite(3'd3, 8'hFF);
    wr_lite(3'd5, 8'hFF);
    rd_lite(3'd3, v); check("R10 flag offset reads 0", v, 8'h00);
    rd_lite(3'd5, v); check("R10 enable offset reads 0", v, 8'h00);
    l_pins = 6'h3F;
    repeat (4) @(negedge clk);
    check("R10 irq stays low", {7'd0, l_irq}, 8'h00);
    rd_lite(3'd0, v); check("R4 unbonded bits read 0", v, 8'h3F);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule